// File: doc/BRIEF.md
# Bidirectional LCD Row Scan Register

This block is the digital heart of a row (common) driver for a dot-matrix LCD panel. It holds one bit per row output. On each line strobe from the panel controller, a scan token moves one stage along the register. The direction of travel can be reversed at run time. The register can run as one long chain or as two independent halves. In dual mode each half has its own feed pin, so the upper and lower parts of a panel can be scanned at the same time.

Each stage is turned into a 2-bit drive-level code. The code depends on the stage bit, the frame alternation input and a blanking input. The high-voltage output stage that follows turns the code into one of four bias voltages. The stage at the far end of the chain is brought out on the opposite edge pin, so a second driver of the same kind can continue the scan. An enable flag marks which edge pin is acting as an output.

The edge pins and the middle pin carry single-bit scan data. They have no valid/ready handshake, and the block cannot apply back-pressure. The register advances only on cycles where `line_stb` is high, and the controller owns that pacing. Every strobe is accepted. When no strobe is present, the register holds its state.

Top module: `row_scan_top`

## Requirements
- R1: While `rst_n` is low, every stage is cleared. With `disp_en`=1 and `frame_alt`=0, every channel then shows code 01.
- R2: Single mode (`dual_sel`=0), `dir_rev`=0. Each strobe loads `left_in` into channel 0, and channel i takes the old channel i-1.
- R3: Single mode, `dir_rev`=1. Each strobe loads `right_in` into channel N-1, and channel i takes the old channel i+1.
- R4: Dual mode (`dual_sel`=1), `dir_rev`=0. Channel 0 takes `left_in` and channel N/2 takes `mid_in`. Each half shifts toward higher channel numbers, and no bit crosses from channel N/2-1 into channel N/2.
- R5: Dual mode, `dir_rev`=1. Channel N-1 takes `right_in` and channel N/2-1 takes `mid_in`. Each half shifts toward lower channel numbers, and no bit crosses from channel N/2 into channel N/2-1.
- R6: Cascade outputs depend on `dir_rev`:
  - With `dir_rev`=0, `right_out` equals channel N-1, `right_oe`=1, and `left_out`/`left_oe` are 0.
  - With `dir_rev`=1, `left_out` equals channel 0, `left_oe`=1, and `right_out`/`right_oe` are 0.
- R7: In a cycle without `line_stb`, no stage changes.
- R8: Each channel k drives `lvl_code[2k+1:2k]`, with the codes V0=00, V1=01, V4=10, V5=11. When `disp_en`=1, the code depends on `frame_alt` and the stage bit:
  - `frame_alt`=1 and bit 1 gives 00; bit 0 gives 10.
  - `frame_alt`=0 and bit 1 gives 11; bit 0 gives 01.
- R9: While `disp_en`=0, every channel shows 00, and the stage contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_stb | input | 1 | One-cycle line strobe that advances the scan |
| dual_sel | input | 1 | 0: one N-stage chain, 1: two N/2-stage halves |
| dir_rev | input | 1 | 0: scan toward higher channels, 1: toward lower |
| frame_alt | input | 1 | Frame alternation (AC) signal |
| disp_en | input | 1 | 0 blanks every output to code 00 |
| left_in | input | 1 | Left edge pin scan input |
| mid_in | input | 1 | Middle pin scan input (dual mode) |
| right_in | input | 1 | Right edge pin scan input |
| left_out | output | 1 | Left edge cascade output |
| left_oe | output | 1 | Left edge pin is driven as output |
| right_out | output | 1 | Right edge cascade output |
| right_oe | output | 1 | Right edge pin is driven as output |
| lvl_code | output | 2*N | Per-channel drive-level code |

## Verification
The shift assertions assume that `dual_sel` and `dir_rev` are steady across a strobe and the cycle after it. This matters because each property compares the new stage values with the inputs and stages sampled at the strobe. The stimulus changes mode and direction only on a strobe cycle whose effect is fully captured, and it holds those inputs while the scoreboard compares. The feed pins are assumed to be defined (no X) at every strobe, so the bench always drives all three pins. It also toggles the unused pins to show that they are ignored.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;
  typedef enum logic [1:0] {
    LVL_0 = 2'b00,
    LVL_1 = 2'b01,
    LVL_4 = 2'b10,
    LVL_5 = 2'b11
  } lvl_t;

  function automatic lvl_t map_level(input logic bit_on, input logic alt, input logic en);
    if (!en)      return LVL_0;
    else if (alt) return bit_on ? LVL_0 : LVL_4;
    else          return bit_on ? LVL_5 : LVL_1;
  endfunction
endpackage

// File: rtl/row_scan_chain.sv
module row_scan_chain #(
  parameter int N = 80
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         line_stb,
  input  logic         dual_sel,
  input  logic         dir_rev,
  input  logic         left_in,
  input  logic         mid_in,
  input  logic         right_in,
  output logic [N-1:0] stages
);
  localparam int H = N / 2;

  logic [N-1:0] nxt;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_stage
      logic up_src, dn_src;
      if (g == 0) begin : g_up_edge
        assign up_src = left_in;
      end else if (g == H) begin : g_up_mid
        assign up_src = dual_sel ? mid_in : stages[g-1];
      end else begin : g_up_pass
        assign up_src = stages[g-1];
      end
      if (g == N-1) begin : g_dn_edge
        assign dn_src = right_in;
      end else if (g == H-1) begin : g_dn_mid
        assign dn_src = dual_sel ? mid_in : stages[g+1];
      end else begin : g_dn_pass
        assign dn_src = stages[g+1];
      end
      assign nxt[g] = dir_rev ? dn_src : up_src;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stages <= '0;
    else if (line_stb) stages <= nxt;
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb |=> $stable(stages));

  assert_single_fwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && !dual_sel && !dir_rev) |=>
      (stages[0] == $past(left_in)) && (stages[N-1:1] == $past(stages[N-2:0])));

  assert_single_rev_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && !dual_sel && dir_rev) |=>
      (stages[N-1] == $past(right_in)) && (stages[N-2:0] == $past(stages[N-1:1])));

  assert_dual_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && dual_sel && !dir_rev) |=>
      (stages[0] == $past(left_in)) && (stages[H] == $past(mid_in)) &&
      (stages[H-1:1] == $past(stages[H-2:0])));

  assert_dual_rev_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && dual_sel && dir_rev) |=>
      (stages[N-1] == $past(right_in)) && (stages[H-1] == $past(mid_in)) &&
      (stages[N-2:H] == $past(stages[N-1:H+1])));
endmodule

// File: rtl/row_level_enc.sv
module row_level_enc
  import row_scan_pkg::*;
#(
  parameter int N = 80
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   stages,
  input  logic           frame_alt,
  input  logic           disp_en,
  output logic [2*N-1:0] lvl_code
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_ch
      assign lvl_code[2*g+1:2*g] = map_level(stages[g], frame_alt, disp_en);
    end
  endgenerate

  assert_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |-> (lvl_code == '0));

  assert_sel_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && stages[0]) |-> (lvl_code[1:0] == (frame_alt ? 2'b00 : 2'b11)));

  assert_nsel_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && !stages[N-1]) |-> (lvl_code[2*N-1:2*N-2] == (frame_alt ? 2'b10 : 2'b01)));
endmodule

// File: rtl/row_scan_top.sv
module row_scan_top #(
  parameter int N = 80
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           line_stb,
  input  logic           dual_sel,
  input  logic           dir_rev,
  input  logic           frame_alt,
  input  logic           disp_en,
  input  logic           left_in,
  input  logic           mid_in,
  input  logic           right_in,
  output logic           left_out,
  output logic           left_oe,
  output logic           right_out,
  output logic           right_oe,
  output logic [2*N-1:0] lvl_code
);
  logic [N-1:0] stages;

  row_scan_chain #(.N(N)) u_chain (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .dual_sel(dual_sel),
    .dir_rev(dir_rev), .left_in(left_in), .mid_in(mid_in),
    .right_in(right_in), .stages(stages)
  );

  row_level_enc #(.N(N)) u_enc (
    .clk(clk), .rst_n(rst_n), .stages(stages), .frame_alt(frame_alt),
    .disp_en(disp_en), .lvl_code(lvl_code)
  );

  assign right_oe  = ~dir_rev;
  assign left_oe   = dir_rev;
  assign right_out = right_oe & stages[N-1];
  assign left_out  = left_oe & stages[0];

  assert_cascade_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({left_oe, right_oe}) && !(left_out && !left_oe) && !(right_out && !right_oe));

  initial assert (N % 2 == 0) else $error("N must be even");
endmodule

// File: tb/row_scan_top_tb.sv
module row_scan_top_tb;
  localparam int N = 80;
  localparam int H = N / 2;

  typedef struct {
    logic [2*N-1:0] lvl;
    logic lo, loe, ro, roe;
    string tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic line_stb = 0, dual_sel = 0, dir_rev = 0, frame_alt = 0, disp_en = 1;
  logic left_in = 0, mid_in = 0, right_in = 0;
  logic left_out, left_oe, right_out, right_oe;
  logic [2*N-1:0] lvl_code;

  always #4 clk = ~clk;

  row_scan_top #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .dual_sel(dual_sel),
    .dir_rev(dir_rev), .frame_alt(frame_alt), .disp_en(disp_en),
    .left_in(left_in), .mid_in(mid_in), .right_in(right_in),
    .left_out(left_out), .left_oe(left_oe), .right_out(right_out),
    .right_oe(right_oe), .lvl_code(lvl_code)
  );

  exp_t q[$];
  logic [N-1:0] model;
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [2*N-1:0] enc(input logic [N-1:0] m, input logic alt, input logic en);
    logic [2*N-1:0] r;
    for (int k = 0; k < N; k++) begin
      if (!en)      r[2*k +: 2] = 2'b00;
      else if (alt) r[2*k +: 2] = m[k] ? 2'b00 : 2'b10;
      else          r[2*k +: 2] = m[k] ? 2'b11 : 2'b01;
    end
    return r;
  endfunction

  task automatic push(input string tag);
    exp_t e;
    e.lvl = enc(model, frame_alt, disp_en);
    e.roe = !dir_rev;  e.loe = dir_rev;
    e.ro  = !dir_rev & model[N-1];
    e.lo  = dir_rev & model[0];
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(input logic stb, input logic l, input logic m, input logic r, input string tag);
    @(negedge clk);
    line_stb = stb; left_in = l; mid_in = m; right_in = r;
    @(posedge clk);
    if (stb) begin
      if (!dual_sel && !dir_rev)     model = {model[N-2:0], l};
      else if (!dual_sel)            model = {r, model[N-1:1]};
      else if (!dir_rev)             model = {model[N-2:H], m, model[H-2:0], l};
      else                           model = {r, model[N-1:H+1], m, model[H-1:1]};
    end
    #1;
    push(tag);
    @(negedge clk);
    line_stb = 0;
  endtask

  initial begin : monitor
    forever begin
      exp_t e;
      wait (q.size() > 0);
      e = q.pop_front();
      checks++;
      if (lvl_code !== e.lvl || left_out !== e.lo || left_oe !== e.loe ||
          right_out !== e.ro || right_oe !== e.roe) begin
        fails++;
        $display("FAIL %s: lvl=%h lo=%b loe=%b ro=%b roe=%b exp lvl=%h lo=%b loe=%b ro=%b roe=%b",
                 e.tag, lvl_code, left_out, left_oe, right_out, right_oe,
                 e.lvl, e.lo, e.loe, e.ro, e.roe);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    model = '0;
    repeat (3) @(posedge clk);
    #1; push("R1 reset clear");
    @(negedge clk); rst_n = 1;
    // R2: single forward, unused pins toggled
    step(1, 1, 1, 1, "R2 single fwd load 1");
    step(1, 0, 1, 1, "R2 single fwd load 0");
    step(1, 1, 0, 0, "R2 single fwd load 1");
    step(0, 1, 1, 1, "R7 hold without strobe");
    for (int i = 0; i < N - 3; i++) step(1, 0, 1, 1, "R6 token walks to right edge");
    // R8 level mapping under both frame phases
    frame_alt = 1; step(0, 0, 0, 0, "R8 frame_alt=1 mapping");
    frame_alt = 0; step(0, 0, 0, 0, "R8 frame_alt=0 mapping");
    // R9 blank keeps contents
    disp_en = 0; step(1, 1, 0, 0, "R9 blank forces 00");
    disp_en = 1; step(0, 0, 0, 0, "R9 contents kept after blank");
    // R3: single reverse
    dir_rev = 1; step(0, 0, 0, 0, "R6 reverse cascade pins");
    step(1, 0, 1, 1, "R3 single rev load 1");
    for (int i = 0; i < N; i++) step(1, 0, 1, (i % 7 == 0), "R3 R6 single rev walk to left edge");
    // R4: dual forward, boundary crossing
    dir_rev = 0; dual_sel = 1;
    step(1, 1, 0, 1, "R4 dual fwd left feed");
    step(1, 0, 1, 1, "R4 dual fwd mid feed");
    for (int i = 0; i < H; i++) step(1, 0, 0, 1, "R4 R6 dual fwd no crossing at mid");
    // R5: dual reverse
    dir_rev = 1;
    step(1, 1, 1, 1, "R5 dual rev both feeds");
    for (int i = 0; i < H + 1; i++) step(1, 1, 0, 0, "R5 R6 dual rev no crossing at mid");
    frame_alt = 1; step(0, 0, 0, 0, "R8 dual pattern alt=1");
    repeat (3) @(posedge clk);
    wait (q.size() == 0);
    #2;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule